// File: doc/BRIEF.md
# Ultra DMA arming and status unit

This block sits between software registers and an Ultra DMA transfer engine. Software programs the transfer direction and enable in an operation register and selects the interface mode in a configuration register. The block only lets the engine run after a strict arming handshake: a direction write with the enable clear, then a readback of the operation register, then a write with the enable set.

While the engine is stopped, the block parks the drive-side chip selects and read/write strobes at their inactive high level. While the engine runs, those lines follow the state machine's outputs. The block gathers the state machine's error, busy and request flags and holds the errors until software clears the operation register. It also reduces all of this, together with the drive interrupt line, to a two-bit prioritised status code.

The block has one word-addressed register port. Register index 0 is the operation register, index 1 the configuration register and index 2 the status word. Read data returns one cycle after the read strobe, together with a valid flag.

Top module: `udma_ctl_stat`

## Requirements
- R1: After reset `dma_en`=0, `dma_dir`=0 and `seq_err`=0. All of `ide_cs_n`, `ide_dior_n` and `ide_diow_n` are 1, `stat_code` is IDLE (0), and reads of registers 0, 1 and 2 return 0.
- R2: In the operation register, bit 0 is the enable and bit 1 the direction, where 1 means host-to-device. The enable takes effect only in this order: a write with bit 0 clear sets the direction; a read of register 0 follows; then a write with bit 0 set and the same direction raises `dma_en` and drives `dma_dir` from bit 1. A read of register 0 returns {dir, en} in bits 1:0.
- R3: A write with bit 0 set that does not follow a direction write and a readback is ignored and sets the sticky `seq_err` flag. A write with bit 0 set while the engine already runs is also ignored, sets `seq_err` and leaves `dma_en` at 1.
- R4: Writing the operation register with bits 1:0 equal to 0 stops the engine, clears `seq_err` and the sticky errors, and returns every chip select and strobe output to 1 one cycle after `dma_en` falls.
- R5: While `dma_en` is 1, `ide_cs_n`, `ide_dior_n` and `ide_diow_n` repeat `sm_cs_n`, `sm_dior_n` and `sm_diow_n` with one cycle of register delay.
- R6: The configuration register holds interface enable (bit 0), PIO select (bit 1), multiword DMA select (bit 2), Ultra DMA select (bit 3), mode number (bits 7:4) and write hold cycles (bits 9:8). These fields drive the `cfg_*` outputs. The register reads back with bits 31:10 as 0.
- R7: The status word (register 2) has request at bit 16, state-machine error at bit 17, busy at bit 18, data-out incomplete at bit 24, data-in incomplete at bit 25 and the not-a-multiple-of-four-words error at bit 26. All other bits are 0.
- R8: `stat_code` is ERROR (3) if any held or incoming error is present. Otherwise it is INTERRUPT (2) if `intrq` is 1, otherwise ACTIVE (1) if busy or request is 1, otherwise IDLE (0). It is registered from the inputs of the same cycle.
- R9: A `xfer_end` pulse whose `xfer_words` count is not a multiple of four sets the bit-26 error. A count that is a multiple of four sets nothing.
- R10: Error bits 17, 24, 25 and 26 stay set after their input falls and clear only on the R4 clearing write.
- R11: A write with bit 0 set whose direction differs from the armed direction is ignored and sets `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| sm_req | input | 1 | Request flag from the transfer state machine |
| sm_errint | input | 1 | State-machine error interrupt |
| sm_busy | input | 1 | State machine not idle |
| sm_ndo | input | 1 | Data-out incomplete error |
| sm_ndi | input | 1 | Data-in incomplete error |
| xfer_end | input | 1 | End-of-transfer pulse |
| xfer_words | input | CNT_W | 32-bit words moved in the ending transfer |
| intrq | input | 1 | Drive interrupt line |
| sm_cs_n | input | NUM_CS | Chip selects from the state machine |
| sm_dior_n | input | 1 | Read strobe from the state machine |
| sm_diow_n | input | 1 | Write strobe from the state machine |
| ide_cs_n | output | NUM_CS | Drive chip selects |
| ide_dior_n | output | 1 | Drive read strobe |
| ide_diow_n | output | 1 | Drive write strobe |
| dma_en | output | 1 | Engine running |
| dma_dir | output | 1 | Direction, 1 = host-to-device |
| seq_err | output | 1 | Sticky arming sequence error |
| cfg_if_en | output | 1 | Interface enable |
| cfg_pio | output | 1 | PIO select |
| cfg_mdma | output | 1 | Multiword DMA select |
| cfg_udma | output | 1 | Ultra DMA select |
| cfg_mode | output | MODE_W | Mode number |
| cfg_hold | output | HOLD_W | Write hold cycles |
| stat_code | output | 2 | Prioritised status code |

## Verification
On every cycle the assertions check four things. The enable can only rise out of the armed state. A sequence error persists until a clearing write. Held errors persist and any non-ERROR code implies no held error. A stopped engine parks the drive lines high on the next cycle.

Other behaviour needs the bench's scenarios. These cover the exact register encodings, the status bit positions, the passing of strobes through while running, the mismatched-direction case, the multiple-of-four word check, and the full priority ladder from ERROR down to IDLE.

// File: rtl/udma_cs_pkg.sv
package udma_cs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_INTR   = 2'd2,
    ST_ERROR  = 2'd3
  } dma_stat_e;

  typedef enum logic [1:0] {
    ARM_OFF   = 2'd0,
    ARM_DIR   = 2'd1,
    ARM_READY = 2'd2,
    ARM_ON    = 2'd3
  } arm_e;

  localparam int OP_EN_BIT  = 0;
  localparam int OP_DIR_BIT = 1;

  localparam int REG_OP   = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_STAT = 2;

  localparam int BIT_REQ    = 16;
  localparam int BIT_ERRINT = 17;
  localparam int BIT_BUSY   = 18;
  localparam int BIT_NDO    = 24;
  localparam int BIT_NDI    = 25;
  localparam int BIT_N4X    = 26;

  typedef struct packed {
    logic n4x;
    logic ndi;
    logic ndo;
    logic errint;
  } err_t;

endpackage

// File: rtl/udma_arm_ctrl.sv
module udma_arm_ctrl
  import udma_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_wr,
  input  logic       op_rd,
  input  logic [1:0] op_bits,
  output logic       en_q,
  output logic       dir_q,
  output logic       seq_err_q,
  output logic       clr
);

  arm_e st_q;
  logic wr_en_bit;
  logic wr_dir_bit;

  assign wr_en_bit  = op_bits[OP_EN_BIT];
  assign wr_dir_bit = op_bits[OP_DIR_BIT];
  assign clr        = op_wr && (op_bits == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ARM_OFF;
      en_q      <= 1'b0;
      dir_q     <= 1'b0;
      seq_err_q <= 1'b0;
    end else if (op_wr) begin
      if (!wr_en_bit) begin
        en_q  <= 1'b0;
        dir_q <= wr_dir_bit;
        st_q  <= ARM_DIR;
        if (clr) seq_err_q <= 1'b0;
      end else if (st_q == ARM_READY && wr_dir_bit == dir_q) begin
        en_q <= 1'b1;
        st_q <= ARM_ON;
      end else begin
        seq_err_q <= 1'b1;
        if (st_q != ARM_ON) st_q <= ARM_OFF;
      end
    end else if (op_rd && st_q == ARM_DIR) begin
      st_q <= ARM_READY;
    end
  end

  assert_arm_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(st_q == ARM_READY));

  assert_seq_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_err_q && !clr) |=> seq_err_q);

endmodule

// File: rtl/udma_stat_dec.sv
module udma_stat_dec
  import udma_cs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sm_req,
  input  logic             sm_errint,
  input  logic             sm_busy,
  input  logic             sm_ndo,
  input  logic             sm_ndi,
  input  logic             xfer_end,
  input  logic [CNT_W-1:0] xfer_words,
  input  logic             intrq,
  output err_t             err_q,
  output logic             req_q,
  output logic             busy_q,
  output dma_stat_e        code_q
);

  localparam int GRAN_BITS = 2;

  err_t      err_in;
  err_t      err_nxt;
  dma_stat_e code_d;

  always_comb begin
    err_in.errint = sm_errint;
    err_in.ndo    = sm_ndo;
    err_in.ndi    = sm_ndi;
    err_in.n4x    = xfer_end && (|xfer_words[GRAN_BITS-1:0]);
    err_nxt       = (clr ? err_t'('0) : err_q) | err_in;
  end

  always_comb begin
    if (|err_nxt)                code_d = ST_ERROR;
    else if (intrq)              code_d = ST_INTR;
    else if (sm_busy || sm_req)  code_d = ST_ACTIVE;
    else                         code_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      code_q <= ST_IDLE;
    end else begin
      err_q  <= err_nxt;
      req_q  <= sm_req;
      busy_q <= sm_busy;
      code_q <= code_d;
    end
  end

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ((|err_q) && !clr) |=> (|err_q));

  assert_code_prio_R8: assert property (@(posedge clk) disable iff (rst)
    (code_q != ST_ERROR) |-> (err_q == '0));

endmodule

// File: rtl/udma_ctl_stat.sv
module udma_ctl_stat
  import udma_cs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 4,
  parameter int CNT_W  = 16,
  parameter int NUM_CS = 2,
  parameter int MODE_W = 4,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              sm_req,
  input  logic              sm_errint,
  input  logic              sm_busy,
  input  logic              sm_ndo,
  input  logic              sm_ndi,
  input  logic              xfer_end,
  input  logic [CNT_W-1:0]  xfer_words,
  input  logic              intrq,
  input  logic [NUM_CS-1:0] sm_cs_n,
  input  logic              sm_dior_n,
  input  logic              sm_diow_n,
  output logic [NUM_CS-1:0] ide_cs_n,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  output logic              dma_en,
  output logic              dma_dir,
  output logic              seq_err,
  output logic              cfg_if_en,
  output logic              cfg_pio,
  output logic              cfg_mdma,
  output logic              cfg_udma,
  output logic [MODE_W-1:0] cfg_mode,
  output logic [HOLD_W-1:0] cfg_hold,
  output logic [1:0]        stat_code
);

  localparam int SEL_W   = 4;
  localparam int MODE_LO = SEL_W;
  localparam int HOLD_LO = SEL_W + MODE_W;
  localparam int CFG_W   = SEL_W + MODE_W + HOLD_W;

  logic              op_wr, op_rd, cfg_wr, clr;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_mux;
  err_t              err_q;
  logic              req_q, busy_q;
  dma_stat_e         code_q;

  assign op_wr  = bus_wr && (bus_addr == AW'(REG_OP));
  assign op_rd  = bus_rd && (bus_addr == AW'(REG_OP));
  assign cfg_wr = bus_wr && (bus_addr == AW'(REG_CFG));

  udma_arm_ctrl u_arm (
    .clk       (clk),
    .rst       (rst),
    .op_wr     (op_wr),
    .op_rd     (op_rd),
    .op_bits   (bus_wdata[1:0]),
    .en_q      (dma_en),
    .dir_q     (dma_dir),
    .seq_err_q (seq_err),
    .clr       (clr)
  );

  udma_stat_dec #(.CNT_W(CNT_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .sm_req     (sm_req),
    .sm_errint  (sm_errint),
    .sm_busy    (sm_busy),
    .sm_ndo     (sm_ndo),
    .sm_ndi     (sm_ndi),
    .xfer_end   (xfer_end),
    .xfer_words (xfer_words),
    .intrq      (intrq),
    .err_q      (err_q),
    .req_q      (req_q),
    .busy_q     (busy_q),
    .code_q     (code_q)
  );

  assign stat_code = code_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_wr) cfg_q <= bus_wdata[CFG_W-1:0];
  end

  assign cfg_if_en = cfg_q[0];
  assign cfg_pio   = cfg_q[1];
  assign cfg_mdma  = cfg_q[2];
  assign cfg_udma  = cfg_q[3];
  assign cfg_mode  = cfg_q[MODE_LO +: MODE_W];
  assign cfg_hold  = cfg_q[HOLD_LO +: HOLD_W];

  always_comb begin
    stat_word             = '0;
    stat_word[BIT_REQ]    = req_q;
    stat_word[BIT_ERRINT] = err_q.errint;
    stat_word[BIT_BUSY]   = busy_q;
    stat_word[BIT_NDO]    = err_q.ndo;
    stat_word[BIT_NDI]    = err_q.ndi;
    stat_word[BIT_N4X]    = err_q.n4x;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(REG_OP):   rd_mux[1:0] = {dma_dir, dma_en};
      AW'(REG_CFG):  rd_mux[CFG_W-1:0] = cfg_q;
      AW'(REG_STAT): rd_mux = stat_word;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CS; gi++) begin : g_cs
      always_ff @(posedge clk) begin
        if (rst) ide_cs_n[gi] <= 1'b1;
        else     ide_cs_n[gi] <= dma_en ? sm_cs_n[gi] : 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ide_dior_n <= 1'b1;
      ide_diow_n <= 1'b1;
    end else begin
      ide_dior_n <= dma_en ? sm_dior_n : 1'b1;
      ide_diow_n <= dma_en ? sm_diow_n : 1'b1;
    end
  end

  assert_strobe_park_R4: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> ((&ide_cs_n) && ide_dior_n && ide_diow_n));

endmodule

// File: tb/sim_udma_ctl_stat.sv
`timescale 1ns/1ps
module sim_udma_ctl_stat;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        sm_req = 0, sm_errint = 0, sm_busy = 0, sm_ndo = 0, sm_ndi = 0;
  logic        xfer_end = 0;
  logic [15:0] xfer_words = '0;
  logic        intrq = 0;
  logic [1:0]  sm_cs_n = 2'b11;
  logic        sm_dior_n = 1, sm_diow_n = 1;
  logic [1:0]  ide_cs_n;
  logic        ide_dior_n, ide_diow_n, dma_en, dma_dir, seq_err;
  logic        cfg_if_en, cfg_pio, cfg_mdma, cfg_udma;
  logic [3:0]  cfg_mode;
  logic [1:0]  cfg_hold;
  logic [1:0]  stat_code;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  udma_ctl_stat u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // scoreboard monitor: compares read data as it appears
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("read without expectation", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 dma_en", {31'b0, dma_en}, 0);
    chk("R1 seq_err", {31'b0, seq_err}, 0);
    chk("R1 strobes", {28'b0, ide_cs_n, ide_dior_n, ide_diow_n}, 32'hF);
    chk("R1 code", {30'b0, stat_code}, 0);
    rd(0, 0, "R1 op read");
    rd(1, 0, "R1 cfg read");
    rd(2, 0, "R1 stat read");

    // R6 configuration fields
    wr(1, 32'h259);
    chk("R6 fields", {22'b0, cfg_hold, cfg_mode, cfg_udma, cfg_mdma, cfg_pio, cfg_if_en}, 32'h259);
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h3FF, "R6 readback mask");

    // R3 enable without arming
    wr(0, 32'h1);
    chk("R3 ignored en", {31'b0, dma_en}, 0);
    chk("R3 seq_err set", {31'b0, seq_err}, 1);
    rd(0, 0, "R3 op unchanged");
    wr(0, 32'h0);
    chk("R4 seq_err cleared", {31'b0, seq_err}, 0);
    wr(0, 32'h1);
    chk("R3 no readback ignored", {31'b0, dma_en}, 0);

    // R2 arming, host-to-device
    wr(0, 32'h2);
    rd(0, 32'h2, "R2 dir readback");
    wr(0, 32'h3);
    chk("R2 enable", {31'b0, dma_en}, 1);
    chk("R2 dir", {31'b0, dma_dir}, 1);
    rd(0, 32'h3, "R2 op running");
    wr(0, 32'h3);
    chk("R3 rewrite keeps en", {31'b0, dma_en}, 1);

    // R5 pass-through while running
    sm_cs_n = 2'b01; sm_dior_n = 1'b0; sm_diow_n = 1'b1;
    step(1);
    chk("R5 pass", {28'b0, ide_cs_n, ide_dior_n, ide_diow_n}, 32'h5);
    sm_cs_n = 2'b10; sm_dior_n = 1'b1; sm_diow_n = 1'b0;
    step(1);
    chk("R5 pass2", {28'b0, ide_cs_n, ide_dior_n, ide_diow_n}, 32'hA);

    // R4 stop parks strobes
    sm_cs_n = 2'b00; sm_dior_n = 1'b0; sm_diow_n = 1'b0;
    wr(0, 32'h0);
    chk("R4 stop", {31'b0, dma_en}, 0);
    chk("R4 seq_err clear", {31'b0, seq_err}, 0);
    step(1);
    chk("R4 strobes park", {28'b0, ide_cs_n, ide_dior_n, ide_diow_n}, 32'hF);

    // R11 direction mismatch
    rd(0, 0, "R11 readback");
    wr(0, 32'h3);
    chk("R11 mismatch ignored", {31'b0, dma_en}, 0);
    chk("R11 seq_err", {31'b0, seq_err}, 1);

    // R2 device-to-host arming
    wr(0, 32'h0);
    rd(0, 0, "R2 readback dir0");
    wr(0, 32'h1);
    chk("R2 enable dir0", {31'b0, dma_en}, 1);
    chk("R2 dir0", {31'b0, dma_dir}, 0);
    wr(0, 32'h0);

    // R8 priority ladder
    chk("R8 idle", {30'b0, stat_code}, 0);
    sm_busy = 1; step(1);
    chk("R8 active busy", {30'b0, stat_code}, 1);
    sm_busy = 0; sm_req = 1; step(1);
    chk("R8 active req", {30'b0, stat_code}, 1);
    rd(2, 32'h0001_0000, "R7 req bit16");
    sm_busy = 1; step(1);
    rd(2, 32'h0005_0000, "R7 req+busy bits");
    sm_req = 0; intrq = 1; step(1);
    chk("R8 intr over active", {30'b0, stat_code}, 2);
    sm_errint = 1; step(1);
    sm_errint = 0;
    chk("R8 error over intr", {30'b0, stat_code}, 3);
    step(2);
    chk("R10 error held", {30'b0, stat_code}, 3);
    rd(2, 32'h0006_0000, "R7 errint bit17");
    wr(0, 32'h0);
    chk("R10 clear to intr", {30'b0, stat_code}, 2);
    intrq = 0; sm_busy = 0; step(1);
    chk("R8 back idle", {30'b0, stat_code}, 0);

    // R9 multiple-of-four check
    xfer_words = 16'd8; xfer_end = 1; step(1); xfer_end = 0;
    chk("R9 multiple ok", {30'b0, stat_code}, 0);
    xfer_words = 16'd6; xfer_end = 1; step(1); xfer_end = 0;
    chk("R9 not multiple", {30'b0, stat_code}, 3);
    rd(2, 32'h0400_0000, "R9 bit26");
    wr(0, 32'h0);
    sm_ndo = 1; step(1); sm_ndo = 0;
    rd(2, 32'h0100_0000, "R7 ndo bit24");
    wr(0, 32'h0);
    sm_ndi = 1; step(1); sm_ndi = 0; step(1);
    rd(2, 32'h0200_0000, "R10 ndi bit25 held");
    wr(0, 32'h0);
    rd(2, 32'h0, "R4 errors cleared");

    step(3);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule